// File: doc/BRIEF.md
# Microcoded Control Sequencer for an 8-bit Bus CPU

This block is the control unit of a small 8-bit CPU built around a shared bus. It holds a micro-step counter and a microcode table that is computed in logic. Each cycle it emits a 15-bit control word with one bit per datapath strobe. The word is selected by the current step and by the upper nibble of the instruction register.

Every instruction begins with the same two fetch steps. The first drives the program counter into the memory address register. The second reads memory into the instruction register and increments the program counter. The execute steps for the decoded opcode follow, and then the counter returns to the first fetch step. An opcode with no execute steps goes straight back to fetching. The halt opcode emits an empty word and stops the sequencer until reset.

The datapath, the memory and the display decoding sit outside this block. It only produces the strobes that steer them.

Top module: `ucs_ctrl_seq`

## Requirements
- R1: While `rst_ni` is low, and asynchronously on its fall, the step counter is 0 and `halted_o` is 0, so `ctrl_o` shows the first fetch word 0x0808.
- R2: In fetch step 0, `ctrl_o` is 0x0808: PC drive (bit 3) and address-register load (bit 11).
- R3: Fetch step 1 always follows fetch step 0. In it, `ctrl_o` is 0x0590: PC increment (bit 4), memory enable (bit 7), memory read drive (bit 8) and instruction-register load (bit 10).
- R4: In the third step of an instruction, the opcode is taken from `ir_i[7:4]` only. The value of `ir_i[3:0]` has no effect on `ctrl_o`.
- R5: The execute word is 0x1200 for opcode 0x1 (IR drive bit 9, A load bit 12), 0x2200 for opcode 0x2 (IR drive bit 9, B load bit 13) and 0x0220 for opcode 0x9 (IR drive bit 9, PC load bit 5).
- R6: The execute word is 0x4001 for opcode 0x3 (A drive bit 0, display load bit 14) and 0x4004 for opcode 0x4 (B drive bit 2, display load bit 14).
- R7: The execute word is 0x1002 for opcode 0x5 and 0x2002 for opcode 0x6, each being ALU drive (bit 1) plus A load or B load. Opcode 0x7 gives 0x1042 and opcode 0x8 gives 0x2042, which add ALU subtract (bit 6).
- R8: In the cycle after the last execute step of an instruction, the sequencer is back in fetch step 0.
- R9: Opcodes 0x0, 0xA to 0xD and 0xF have no execute step. The third step shows the fetch-0 word 0x0808, and fetch step 1 follows it.
- R10: Opcode 0xE gives an all-zero word in its execute step. `halted_o` rises in the next cycle. After that, `ctrl_o` stays 0 whatever `ir_i` does, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset, released synchronously to clk_i |
| ir_i | input | 8 | Current instruction register value |
| ctrl_o | output | 15 | Control word, one bit per datapath strobe |
| halted_o | output | 1 | High once a halt opcode has executed |

## Verification
The bench sets the instruction register only after the fetch-1 step. A design that decoded the opcode one cycle early would show the wrong execute word, and the bench sees that. Undefined opcodes are checked for the shortcut to fetch step 1. A design that inserted an empty step, or restarted at step 0, would put the wrong word in that cycle or the next one. The halt checks change `ir_i` after halting to find a sequencer that keeps counting, and they look for a missing or late `halted_o`. Reset is applied both between instructions and in the middle of a fetch, to expose a counter that resets only on a clock edge.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

  localparam int unsigned CTRL_W  = 15;
  localparam int unsigned FETCH_N = 2;

  // control word bit positions (fixed, decoded by the datapath)
  localparam int unsigned CB_A_DRV   = 0;
  localparam int unsigned CB_ALU_DRV = 1;
  localparam int unsigned CB_B_DRV   = 2;
  localparam int unsigned CB_PC_DRV  = 3;
  localparam int unsigned CB_PC_INC  = 4;
  localparam int unsigned CB_PC_LD   = 5;
  localparam int unsigned CB_ALU_SUB = 6;
  localparam int unsigned CB_MEM_EN  = 7;
  localparam int unsigned CB_MEM_RD  = 8;
  localparam int unsigned CB_IR_DRV  = 9;
  localparam int unsigned CB_IR_LD   = 10;
  localparam int unsigned CB_MAR_LD  = 11;
  localparam int unsigned CB_A_LD    = 12;
  localparam int unsigned CB_B_LD    = 13;
  localparam int unsigned CB_DISP_LD = 14;

  typedef logic [CTRL_W-1:0] ctrl_word_t;

  typedef enum logic [3:0] {
    OPC_LD_A   = 4'h1,
    OPC_LD_B   = 4'h2,
    OPC_SHOW_A = 4'h3,
    OPC_SHOW_B = 4'h4,
    OPC_ADD_A  = 4'h5,
    OPC_ADD_B  = 4'h6,
    OPC_SUB_A  = 4'h7,
    OPC_SUB_B  = 4'h8,
    OPC_JUMP   = 4'h9,
    OPC_HALT   = 4'hE
  } opc_e;

  function automatic ctrl_word_t bit_of(input int unsigned pos);
    ctrl_word_t w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction

  function automatic ctrl_word_t fetch_word(input int unsigned s);
    if (s == 0) return bit_of(CB_PC_DRV) | bit_of(CB_MAR_LD);
    return bit_of(CB_IR_LD) | bit_of(CB_MEM_RD) | bit_of(CB_MEM_EN) | bit_of(CB_PC_INC);
  endfunction

  function automatic int unsigned exec_len(input logic [3:0] op);
    case (op)
      OPC_LD_A, OPC_LD_B, OPC_SHOW_A, OPC_SHOW_B, OPC_ADD_A, OPC_ADD_B,
      OPC_SUB_A, OPC_SUB_B, OPC_JUMP, OPC_HALT: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_halt(input logic [3:0] op);
    return op == OPC_HALT;
  endfunction

  function automatic ctrl_word_t exec_word(input logic [3:0] op, input int unsigned idx);
    if (idx != 0) return '0;
    case (op)
      OPC_LD_A:   return bit_of(CB_IR_DRV) | bit_of(CB_A_LD);
      OPC_LD_B:   return bit_of(CB_IR_DRV) | bit_of(CB_B_LD);
      OPC_SHOW_A: return bit_of(CB_A_DRV) | bit_of(CB_DISP_LD);
      OPC_SHOW_B: return bit_of(CB_B_DRV) | bit_of(CB_DISP_LD);
      OPC_ADD_A:  return bit_of(CB_ALU_DRV) | bit_of(CB_A_LD);
      OPC_ADD_B:  return bit_of(CB_ALU_DRV) | bit_of(CB_B_LD);
      OPC_SUB_A:  return bit_of(CB_ALU_DRV) | bit_of(CB_ALU_SUB) | bit_of(CB_A_LD);
      OPC_SUB_B:  return bit_of(CB_ALU_DRV) | bit_of(CB_ALU_SUB) | bit_of(CB_B_LD);
      OPC_JUMP:   return bit_of(CB_IR_DRV) | bit_of(CB_PC_LD);
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/ucs_udecode.sv
module ucs_udecode
  import ucs_pkg::*;
#(
  parameter int unsigned STEP_MAX = 6,
  parameter int unsigned STEP_W   = $clog2(STEP_MAX)
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [3:0]        op_i,
  output ctrl_word_t        word_o,
  output logic [STEP_W-1:0] step_nxt_o,
  output logic              halt_set_o
);

  ctrl_word_t step_tbl [STEP_MAX];

  // one microcode word per step slot: fetch slots fixed, execute slots per opcode
  for (genvar s = 0; s < STEP_MAX; s++) begin : g_slot
    if (s < FETCH_N) begin : g_fetch
      assign step_tbl[s] = fetch_word(s);
    end else begin : g_exec
      assign step_tbl[s] = exec_word(op_i, s - FETCH_N);
    end
  end

  int unsigned st;
  int unsigned len;

  always_comb begin
    st         = 32'(step_i);
    len        = exec_len(op_i);
    word_o     = step_tbl[0];
    step_nxt_o = '0;
    halt_set_o = 1'b0;
    if (st < FETCH_N) begin
      word_o     = step_tbl[step_i];
      step_nxt_o = STEP_W'(st + 1);
    end else if (len == 0) begin
      // no execute steps: this slot acts as fetch step 0
      word_o     = step_tbl[0];
      step_nxt_o = STEP_W'(1);
    end else if (st < STEP_MAX) begin
      word_o     = step_tbl[step_i];
      halt_set_o = is_halt(op_i);
      step_nxt_o = (st - FETCH_N + 1 >= len) ? '0 : STEP_W'(st + 1);
    end
  end

endmodule

// File: rtl/ucs_stepctr.sv
module ucs_stepctr #(
  parameter int unsigned STEP_MAX = 6,
  parameter int unsigned STEP_W   = $clog2(STEP_MAX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_nxt_i,
  input  logic              halt_set_i,
  output logic [STEP_W-1:0] step_o,
  output logic              halted_o
);

  logic [STEP_W-1:0] step_q, step_d;
  logic              halted_q, halted_d;
  logic              cnt_en;

  assign cnt_en = ~halted_q;

  always_comb begin
    step_d   = step_q;
    halted_d = halted_q;
    if (cnt_en) begin
      step_d   = step_nxt_i;
      halted_d = halt_set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      halted_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      halted_q <= halted_d;
    end
  end

  assign step_o   = step_q;
  assign halted_o = halted_q;

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q); // R10

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(step_q) < STEP_MAX); // R8

  AST_FETCH_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == '0 && !halted_q) |=> (step_q == STEP_W'(1))); // R3

endmodule

// File: rtl/ucs_ctrl_seq.sv
module ucs_ctrl_seq
  import ucs_pkg::*;
#(
  parameter int unsigned STEP_MAX = 6,
  parameter int unsigned IR_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IR_W-1:0]   ir_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              halted_o
);

  localparam int unsigned STEP_W = $clog2(STEP_MAX);

  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] step_nxt;
  logic              halt_set;
  logic              halted;
  ctrl_word_t        word;
  logic              unused_low;

  assign unused_low = ^ir_i[IR_W-5:0];

  ucs_udecode #(
    .STEP_MAX (STEP_MAX),
    .STEP_W   (STEP_W)
  ) udecode_i (
    .step_i     (step),
    .op_i       (ir_i[IR_W-1:IR_W-4]),
    .word_o     (word),
    .step_nxt_o (step_nxt),
    .halt_set_o (halt_set)
  );

  ucs_stepctr #(
    .STEP_MAX (STEP_MAX),
    .STEP_W   (STEP_W)
  ) stepctr_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_nxt_i (step_nxt),
    .halt_set_i (halt_set),
    .step_o     (step),
    .halted_o   (halted)
  );

  assign ctrl_o   = halted ? '0 : word;
  assign halted_o = halted;

  AST_HALT_STEP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> ($past(ctrl_o) == '0)); // R10

  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(ctrl_o)); // R10

  AST_FETCH_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[CB_MAR_LD] && !halted_o) |=> ctrl_o[CB_IR_LD]); // R3

endmodule

// File: tb/ucs_ctrl_seq_tb.sv
module ucs_ctrl_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [14:0] W_F0 = 15'h0808;
  localparam logic [14:0] W_F1 = 15'h0590;

  typedef struct packed {
    logic [7:0]  ir;
    logic [14:0] exp;
    logic        undef;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h13, 15'h1200, 1'b0, 8'd5},  // R5 load A
    '{8'h2A, 15'h2200, 1'b0, 8'd5},  // R5 load B
    '{8'h3F, 15'h4001, 1'b0, 8'd6},  // R6 show A
    '{8'h40, 15'h4004, 1'b0, 8'd6},  // R6 show B
    '{8'h57, 15'h1002, 1'b0, 8'd7},  // R7 add into A
    '{8'h61, 15'h2002, 1'b0, 8'd7},  // R7 add into B
    '{8'h7C, 15'h1042, 1'b0, 8'd7},  // R7 sub into A
    '{8'h85, 15'h2042, 1'b0, 8'd7},  // R7 sub into B
    '{8'h9E, 15'h0220, 1'b0, 8'd5},  // R5 jump
    '{8'h00, 15'h0808, 1'b1, 8'd9},  // R9 undefined
    '{8'hA3, 15'h0808, 1'b1, 8'd9},  // R9 undefined
    '{8'h1F, 15'h1200, 1'b0, 8'd4},  // R4 low nibble ignored
    '{8'hF7, 15'h0808, 1'b1, 8'd9},  // R9 undefined
    '{8'hB0, 15'h0808, 1'b1, 8'd9},  // R9 undefined
    '{8'h10, 15'h1200, 1'b0, 8'd4}   // R4 low nibble ignored
  };

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  ir_i;
  logic [14:0] ctrl_o;
  logic        halted_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ucs_ctrl_seq dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ir_i     (ir_i),
    .ctrl_o   (ctrl_o),
    .halted_o (halted_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step_clk();
    @(negedge clk_i);
  endtask

  initial begin
    bit skip_f0;
    rst_ni = 1'b0;
    ir_i   = 8'h00;
    repeat (3) step_clk();
    chk("R1 reset word", 32'(ctrl_o), 32'(W_F0));
    chk("R1 reset halted", 32'(halted_o), 0);
    rst_ni = 1'b1;

    skip_f0 = 0;
    for (int i = 0; i < NV; i++) begin
      if (!skip_f0) begin
        chk("R2/R8 fetch0", 32'(ctrl_o), 32'(W_F0));
        step_clk();
      end
      chk("R3 fetch1", 32'(ctrl_o), 32'(W_F1));
      ir_i = VECS[i].ir;
      step_clk();
      chk($sformatf("R%0d op 0x%02h", VECS[i].req, VECS[i].ir), 32'(ctrl_o), 32'(VECS[i].exp));
      chk("R10 not halted", 32'(halted_o), 0);
      step_clk();
      skip_f0 = VECS[i].undef;
    end

    // R8: after the last execute step the sequencer is at fetch 0
    chk("R8 wrap to fetch0", 32'(ctrl_o), 32'(W_F0));
    step_clk();
    chk("R3 fetch1 before halt", 32'(ctrl_o), 32'(W_F1));
    ir_i = 8'hE9;
    step_clk();
    chk("R10 halt step word", 32'(ctrl_o), 0);
    chk("R10 halted late", 32'(halted_o), 0);
    step_clk();
    chk("R10 halted set", 32'(halted_o), 1);
    chk("R10 halted word", 32'(ctrl_o), 0);
    ir_i = 8'h13;
    for (int k = 0; k < 4; k++) begin
      step_clk();
      chk("R10 stays quiet", 32'(ctrl_o), 0);
      chk("R10 stays halted", 32'(halted_o), 1);
    end

    // R1: asynchronous reset clears the halt
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 async halted clear", 32'(halted_o), 0);
    chk("R1 async word", 32'(ctrl_o), 32'(W_F0));
    step_clk();
    rst_ni = 1'b1;
    chk("R2 fetch0 after reset", 32'(ctrl_o), 32'(W_F0));
    step_clk();
    chk("R3 fetch1 after reset", 32'(ctrl_o), 32'(W_F1));
    ir_i = 8'h25;
    step_clk();
    chk("R5 load B after reset", 32'(ctrl_o), 32'h2200);
    step_clk();
    chk("R8 wrap after reset", 32'(ctrl_o), 32'(W_F0));
    step_clk();
    // reset in the middle of fetch step 1
    rst_ni = 1'b0;
    #1;
    chk("R1 mid-fetch reset", 32'(ctrl_o), 32'(W_F0));
    step_clk();
    rst_ni = 1'b1;
    step_clk();
    chk("R3 fetch1 after mid reset", 32'(ctrl_o), 32'(W_F1));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule